// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Decoder

This block is the receiving end of the serial link that drives a two-channel, 10-bit digital-to-analog converter. A host lowers the frame select line and clocks in one 16-bit word. The first four bits are a command, the next ten bits are a code, and the last two bits are padding. When the select line goes high again, the block decodes the word. It then acts on a pair of input (staging) registers, a pair of output (DAC) registers and a single power state. The two DAC register values and a per-channel output-enable are brought out to the converter core. Output-enable low stands for a high-impedance output while the part sleeps. The analog conversion itself lies outside this block.

The serial lines are oversampled by the system clock. They pass through a short synchronizer, and edges are found by comparison with the previous sample. The staging registers let a host load both channels and then update them together. The combined commands load and update in a single frame.

Top module: `dual_dac_cmd`

## Requirements
- R1: After reset, both DAC codes read 0, both output-enables are low (asleep), and both input registers hold 0.
- R2: A frame is shifted in most significant bit first on rising serial clock edges while select is low. Bits 15..12 are the command and bits 11..2 are the code; bits 1..0 have no effect.
- R3: When select rises, a frame whose bit count is other than exactly 16 (15 or 17, for example) is discarded and changes no register or power state.
- R4: Command 4'b0000 changes nothing.
- R5: Commands 4'b0001 and 4'b0010 load the code into input register A or B respectively. The DAC codes and the power state stay as they were.
- R6: Command 4'b1000 copies input A and input B into the DAC registers and sets the part awake.
- R7: Command 4'b1001 loads the code into input A, sets DAC A to the new code and DAC B to the existing input B, and wakes the part.
- R8: Command 4'b1010 loads the code into input B, sets DAC A to the existing input A and DAC B to the new code, and wakes the part.
- R9: Command 4'b1101 wakes the part and 4'b1110 puts it to sleep. Neither alters any register, and both output-enables always follow the power state.
- R10: Command 4'b1111 loads the code into both input registers and both DAC registers and wakes the part.
- R11: Commands 4'b0011 to 4'b0111, 4'b1011 and 4'b1100 are reserved, and they leave every register and the power state unchanged.
- R12: The DAC codes never change while select is held low, and a DAC code only changes together with the part being awake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock; data is taken on its rising edge |
| spi_csn | input | 1 | Active-low frame select; its rising edge ends a frame |
| spi_sdi | input | 1 | Serial data in |
| dac_a_code | output | 10 | Channel A DAC register |
| dac_b_code | output | 10 | Channel B DAC register |
| dac_a_oe | output | 1 | Channel A output drive enable (low means high impedance) |
| dac_b_oe | output | 1 | Channel B output drive enable (low means high impedance) |

## Verification
Input-only loads are followed by a bare update. This shows that the staging registers are separate from the DAC registers, and that the update takes whatever the staging registers hold. The combined load-and-update codes are each preceded by a load of the opposite channel. This tells "new" data apart from "existing" data on each side. An asymmetric code with padding bits set shows whether the bit order is reversed or the padding leaks into the data. The reserved codes, the no-op and frames of 15 and 17 bits all carry non-zero data, and each is followed by an update. Any register they touched by mistake then shows at the outputs.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

    parameter int unsigned DAC_CODE_W  = 10;
    parameter int unsigned CMD_FIELD_W = 4;
    parameter int unsigned WORD_W      = 16;

    // Command field values; any value not listed is reserved and inert.
    typedef enum logic [3:0] {
        CMD_NOP        = 4'b0000,
        CMD_STAGE_A    = 4'b0001,
        CMD_STAGE_B    = 4'b0010,
        CMD_COMMIT     = 4'b1000,
        CMD_STAGE_A_GO = 4'b1001,
        CMD_STAGE_B_GO = 4'b1010,
        CMD_WAKE       = 4'b1101,
        CMD_SLEEP      = 4'b1110,
        CMD_ALL_GO     = 4'b1111
    } dac_cmd_e;

endpackage

// File: rtl/dual_dac_sampler.sv
// Synchronizes the serial lines into the clk domain and detects edges.
module dual_dac_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic csn_in,
    input  logic sdi_in,
    output logic sck_rise,
    output logic sel_rise,
    output logic sel_active,
    output logic sdi_sync
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sck_pipe;
        logic [SYNC_STAGES-1:0] csn_pipe;
        logic [SYNC_STAGES-1:0] sdi_pipe;
        logic                   sck_prev;
        logic                   csn_prev;
    } samp_t;

    samp_t st_d, st_q;

    logic sck_s, csn_s;

    assign sck_s = st_q.sck_pipe[SYNC_STAGES-1];
    assign csn_s = st_q.csn_pipe[SYNC_STAGES-1];

    always_comb begin
        st_d          = st_q;
        st_d.sck_pipe = SYNC_STAGES'({st_q.sck_pipe, sck_in});
        st_d.csn_pipe = SYNC_STAGES'({st_q.csn_pipe, csn_in});
        st_d.sdi_pipe = SYNC_STAGES'({st_q.sdi_pipe, sdi_in});
        st_d.sck_prev = sck_s;
        st_d.csn_prev = csn_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck_pipe <= '0;
            st_q.csn_pipe <= '1;
            st_q.sdi_pipe <= '0;
            st_q.sck_prev <= 1'b0;
            st_q.csn_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_rise   = sck_s & ~st_q.sck_prev;
    assign sel_rise   = csn_s & ~st_q.csn_prev;
    assign sel_active = ~csn_s;
    assign sdi_sync   = st_q.sdi_pipe[SYNC_STAGES-1];

endmodule

// File: rtl/dual_dac_shifter.sv
// Collects serial bits MSB first and flags a frame of exactly WORD_W bits.
module dual_dac_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sel_rise,
    input  logic              sel_active,
    input  logic              sdi_sync,
    output logic              word_stb,
    output logic [WORD_W-1:0] word
);

    localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
    localparam int unsigned CNT_SAT = WORD_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  nbits;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (sel_active) begin
            if (sck_rise) begin
                sh_d.shreg = {sh_q.shreg[WORD_W-2:0], sdi_sync};
                if (sh_q.nbits != CNT_W'(CNT_SAT)) begin
                    sh_d.nbits = sh_q.nbits + 1'b1;
                end
            end
        end else begin
            sh_d.nbits = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word_stb = sel_rise && (sh_q.nbits == CNT_W'(WORD_W));
    assign word     = sh_q.shreg;

endmodule

// File: rtl/dual_dac_regs.sv
// Decodes a received word and updates staging, DAC and power state.
module dual_dac_regs
    import dual_dac_pkg::*;
#(
    parameter int unsigned WORD_W = dual_dac_pkg::WORD_W,
    parameter int unsigned CMD_W  = dual_dac_pkg::CMD_FIELD_W,
    parameter int unsigned DATA_W = dual_dac_pkg::DAC_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b,
    output logic              awake
);

    localparam int unsigned PAD_W = WORD_W - CMD_W - DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] stage_a;
        logic [DATA_W-1:0] stage_b;
        logic [DATA_W-1:0] live_a;
        logic [DATA_W-1:0] live_b;
        logic              on;
    } reg_t;

    reg_t rg_d, rg_q;

    logic [CMD_W-1:0]  cmd_raw;
    logic [DATA_W-1:0] code;
    logic              unused_pad;

    assign cmd_raw    = word[WORD_W-1 -: CMD_W];
    assign code       = word[WORD_W-CMD_W-1 -: DATA_W];
    assign unused_pad = ^word[PAD_W-1:0];

    always_comb begin
        rg_d = rg_q;
        if (word_stb) begin
            case (dac_cmd_e'(cmd_raw))
                CMD_STAGE_A: rg_d.stage_a = code;
                CMD_STAGE_B: rg_d.stage_b = code;
                CMD_COMMIT: begin
                    rg_d.live_a = rg_q.stage_a;
                    rg_d.live_b = rg_q.stage_b;
                    rg_d.on     = 1'b1;
                end
                CMD_STAGE_A_GO: begin
                    rg_d.stage_a = code;
                    rg_d.live_a  = code;
                    rg_d.live_b  = rg_q.stage_b;
                    rg_d.on      = 1'b1;
                end
                CMD_STAGE_B_GO: begin
                    rg_d.stage_b = code;
                    rg_d.live_a  = rg_q.stage_a;
                    rg_d.live_b  = code;
                    rg_d.on      = 1'b1;
                end
                CMD_WAKE:  rg_d.on = 1'b1;
                CMD_SLEEP: rg_d.on = 1'b0;
                CMD_ALL_GO: begin
                    rg_d.stage_a = code;
                    rg_d.stage_b = code;
                    rg_d.live_a  = code;
                    rg_d.live_b  = code;
                    rg_d.on      = 1'b1;
                end
                default: rg_d = rg_q;  // no-op and reserved values
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign out_a = rg_q.live_a;
    assign out_b = rg_q.live_b;
    assign awake = rg_q.on;

endmodule

// File: rtl/dual_dac_cmd.sv
module dual_dac_cmd #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WORD_W      = dual_dac_pkg::WORD_W,
    parameter int unsigned CMD_W       = dual_dac_pkg::CMD_FIELD_W,
    parameter int unsigned DATA_W      = dual_dac_pkg::DAC_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_sdi,
    output logic [DATA_W-1:0] dac_a_code,
    output logic [DATA_W-1:0] dac_b_code,
    output logic              dac_a_oe,
    output logic              dac_b_oe
);

    logic              sck_rise, sel_rise, sel_active, sdi_sync;
    logic              word_stb;
    logic [WORD_W-1:0] word;
    logic              awake;

    dual_dac_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_in     (spi_sck),
        .csn_in     (spi_csn),
        .sdi_in     (spi_sdi),
        .sck_rise   (sck_rise),
        .sel_rise   (sel_rise),
        .sel_active (sel_active),
        .sdi_sync   (sdi_sync)
    );

    dual_dac_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise   (sck_rise),
        .sel_rise   (sel_rise),
        .sel_active (sel_active),
        .sdi_sync   (sdi_sync),
        .word_stb   (word_stb),
        .word       (word)
    );

    dual_dac_regs #(
        .WORD_W (WORD_W),
        .CMD_W  (CMD_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_stb (word_stb),
        .word     (word),
        .out_a    (dac_a_code),
        .out_b    (dac_b_code),
        .awake    (awake)
    );

    // Both channels share one power state.
    assign dac_a_oe = awake;
    assign dac_b_oe = awake;

endmodule

// File: rtl/dual_dac_cmd_chk.sv
module dual_dac_cmd_chk #(
    parameter int unsigned DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_csn,
    input logic [DATA_W-1:0] dac_a_code,
    input logic [DATA_W-1:0] dac_b_code,
    input logic              dac_a_oe,
    input logic              dac_b_oe
);

    // R1: one edge into reset, everything is cleared and asleep
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (dac_a_code == '0 && dac_b_code == '0 && !dac_a_oe && !dac_b_oe));

    // R9: both enables follow the single power state
    a_r9_oe_pair: assert property (@(posedge clk) disable iff (!rst_n)
        dac_a_oe == dac_b_oe);

    // R9: going to sleep leaves the DAC registers as they were
    a_r9_sleep_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_a_oe) |-> ($stable(dac_a_code) && $stable(dac_b_code)));

    // R12: no DAC change while select stays low
    a_r12_quiet_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_csn && $past(!spi_csn)) |-> ($stable(dac_a_code) && $stable(dac_b_code)));

    // R12: a DAC code changes only together with the part awake
    a_r12_change_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_a_code) || !$stable(dac_b_code)) |-> dac_a_oe);

endmodule

bind dual_dac_cmd dual_dac_cmd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_csn    (spi_csn),
    .dac_a_code (dac_a_code),
    .dac_b_code (dac_b_code),
    .dac_a_oe   (dac_a_oe),
    .dac_b_oe   (dac_b_oe)
);

// File: tb/dual_dac_cmd_test.sv
`timescale 1ns/1ps
module dual_dac_cmd_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_sdi = 1'b0;
    logic [9:0] dac_a_code, dac_b_code;
    logic       dac_a_oe, dac_b_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state derived from the requirements
    logic [9:0] m_sa = '0, m_sb = '0, m_la = '0, m_lb = '0;
    logic       m_on = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dual_dac_cmd uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (spi_sck),
        .spi_csn    (spi_csn),
        .spi_sdi    (spi_sdi),
        .dac_a_code (dac_a_code),
        .dac_b_code (dac_b_code),
        .dac_a_oe   (dac_a_oe),
        .dac_b_oe   (dac_b_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sends the low nbits of w, most significant first
    task automatic shift_bits(input logic [31:0] w, input int nbits);
        spi_csn = 1'b0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_sdi = w[i];
            spi_sck = 1'b0;
            wait_clk(4);
            spi_sck = 1'b1;
            wait_clk(4);
        end
        spi_sck = 1'b0;
        wait_clk(4);
        spi_csn = 1'b1;
        wait_clk(12);
    endtask

    task automatic model(input logic [3:0] c, input logic [9:0] d);
        case (c)
            4'b0001: m_sa = d;
            4'b0010: m_sb = d;
            4'b1000: begin m_la = m_sa; m_lb = m_sb; m_on = 1'b1; end
            4'b1001: begin m_sa = d; m_la = d; m_lb = m_sb; m_on = 1'b1; end
            4'b1010: begin m_sb = d; m_la = m_sa; m_lb = d; m_on = 1'b1; end
            4'b1101: m_on = 1'b1;
            4'b1110: m_on = 1'b0;
            4'b1111: begin m_sa = d; m_sb = d; m_la = d; m_lb = d; m_on = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic send(input logic [3:0] c, input logic [9:0] d, input logic [1:0] pad);
        shift_bits({16'h0, c, d, pad}, 16);
        model(c, d);
    endtask

    task automatic check(input string tag);
        checks++;
        if (dac_a_code !== m_la || dac_b_code !== m_lb ||
            dac_a_oe !== m_on || dac_b_oe !== m_on) begin
            fails++;
            $display("FAIL %s: got a=%h b=%h oe=%b%b expected a=%h b=%h oe=%b%b",
                     tag, dac_a_code, dac_b_code, dac_a_oe, dac_b_oe,
                     m_la, m_lb, m_on, m_on);
        end
    endtask

    task automatic t_reset();
        check("R1 reset state");
        // R1: input registers are zero too: a commit must yield zeros
        send(4'b1000, 10'h000, 2'b00);
        check("R1 inputs zero after reset");
    endtask

    task automatic t_stage_then_commit();
        send(4'b1110, 10'h000, 2'b00);
        send(4'b0001, 10'h155, 2'b00);
        send(4'b0010, 10'h2AA, 2'b00);
        check("R5 staging leaves DAC and sleep state");
        send(4'b1000, 10'h3FF, 2'b00);
        check("R6 commit copies staged values and wakes");
    endtask

    task automatic t_format();
        send(4'b1111, 10'h203, 2'b11);
        check("R2 bit order and padding ignored");
        checks++;
        if (dac_a_code !== 10'h203) begin
            fails++;
            $display("FAIL R2 explicit code: got %h expected %h", dac_a_code, 10'h203);
        end
    endtask

    task automatic t_stage_a_go();
        send(4'b0010, 10'h0F0, 2'b00);
        send(4'b1001, 10'h3C3, 2'b00);
        check("R7 new A with existing B");
    endtask

    task automatic t_stage_b_go();
        send(4'b0001, 10'h011, 2'b00);
        send(4'b1010, 10'h099, 2'b00);
        check("R8 existing A with new B");
    endtask

    task automatic t_sleep_wake();
        send(4'b1110, 10'h123, 2'b00);
        check("R9 sleep keeps codes, drops enables");
        send(4'b1101, 10'h321, 2'b00);
        check("R9 wake restores enables, codes unchanged");
    endtask

    task automatic t_all_go();
        send(4'b1110, 10'h000, 2'b00);
        send(4'b1111, 10'h3FF, 2'b00);
        check("R10 same code to both channels and wake");
    endtask

    task automatic t_inert_codes();
        send(4'b0000, 10'h155, 2'b00);
        check("R4 no-op");
        foreach (rsv_list[k]) begin
            send(rsv_list[k], 10'h155, 2'b00);
            check($sformatf("R11 reserved %b", rsv_list[k]));
        end
        send(4'b1000, 10'h000, 2'b00);
        check("R11 staging untouched by reserved codes");
    endtask

    task automatic t_bad_length();
        shift_bits({17'h0, 4'b1111, 10'h0AB, 2'b00} >> 1, 15);
        check("R3 15-bit frame discarded");
        shift_bits({15'h0, 4'b1111, 10'h0AB, 2'b00, 1'b1}, 17);
        check("R3 17-bit frame discarded");
        send(4'b1000, 10'h000, 2'b00);
        check("R3 staging untouched by short/long frames");
        send(4'b1111, 10'h0AB, 2'b00);
        check("R3 exact 16-bit frame accepted");
    endtask

    logic [3:0] rsv_list [7] = '{4'b0011, 4'b0100, 4'b0101, 4'b0110,
                                 4'b0111, 4'b1011, 4'b1100};

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_stage_then_commit();
        t_format();
        t_stage_a_go();
        t_stage_b_go();
        t_sleep_wake();
        t_all_go();
        t_inert_codes();
        t_bad_length();
        finish_run();
    end

endmodule